// File: doc/BRIEF.md
# Operation-Type Timing Window Controller

This block sequences the active period of each instruction class in a word-serial machine. A 4-bit class code is decoded into one of sixteen class enables, and a single registered window signal decides the clock cycles in which the selected class may act. The datapaths that these enables gate are outside the block.

Each clock cycle is one digit time, and a word lasts `WORD_LEN` cycles. The surrounding machine supplies a pulse on the first digit of every word, a pulse on the middle digit, and a word counter that advances once per word. After a start request, the window waits for the opening pulse that applies to the latched class. It then stays open until the closing rule of that class ends it. Depending on the class, the window closes on an address match running out, after a fixed number of cycles, or when an external completion signal arrives.

Class codes are assigned as follows:
- Bits [3:1] select one of eight decode pairs, and bit 0 picks the member of the pair, so the enable index equals the code value.
- 0: store to memory word. 1: load from memory word.
- 2: register read. 3: register write.
- 4: card punch. 5: card read.
- 6: immediate load. 7: logic.
- 8: arithmetic. 9: direct stimulate.
- Codes 10 to 15 are unused.

Top module: `op_window_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until a start is accepted, `win` and `en` are 0.
- R2: While `win` is 1, `en` has exactly bit `op` set, where `op` is the code latched at the accepted start. While `win` is 0, `en` is 0.
- R3: For every legal code except 6, `win` rises one cycle after the first clock edge that samples `p_first` high while a request is pending. A start sampled at an edge makes the request pending from the next edge on.
- R4: For code 6, the window opens one cycle after the first pending `p_mid` instead, and stays high for exactly `WORD_LEN/2` cycles.
- R5: For codes 0 and 1, `win` falls after the edge that samples `word_cnt` different from the latched `addr` while it was equal at the previous edge and `win` is high. Expressed from the opening word `w`, the window lasts `WORD_LEN*(((addr-w) mod 2^AW)+1)` cycles.
- R6: For codes 2, 3, 7 and 9, `win` stays high for exactly `WORD_LEN` cycles, whatever `card_exit` and `arith_done` do.
- R7: For codes 4 and 5, `win` falls after the first edge that samples `card_exit` high while `win` is high.
- R8: For code 8, `win` falls after the first edge that samples `arith_done` high while `win` is high.
- R9: A start sampled while a request is pending or the window is open is ignored. The class and the address are not replaced, and no second window follows.
- R10: A start carrying a code from 10 to 15 is ignored, and no window opens for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Digit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| op_type | input | 4 | Class code, sampled with `start` |
| addr | input | AW | Word address, sampled with `start` |
| word_cnt | input | AW | Word counter of the machine |
| p_first | input | 1 | Pulse on the first digit of each word |
| p_mid | input | 1 | Pulse on the middle digit of each word |
| card_exit | input | 1 | Card-exit completion for codes 4 and 5 |
| arith_done | input | 1 | Completion for code 8 |
| win | output | 1 | Registered active window |
| en | output | 16 | Per-class enables, each gated by `win` |

## Verification
Random operations are issued from every digit position. The bench checks the digit at which the window opens, so a controller that opened on the wrong pulse, or one cycle late, shows a shifted opening digit. Match-closed windows are sized so that they span one to four words; a design that closed on the start of a match, instead of its end, would come out a whole word short. Second starts are fired both while a request is pending and during the last open cycle, and a code from 10 to 15 is tried as well. A design that re-latched any of these would show a changed enable or a stray second window.

// File: rtl/op_window_ctrl.sv
module op_window_ctrl #(
  parameter int WORD_LEN = 32,
  parameter int AW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op_type,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] word_cnt,
  input  logic          p_first,
  input  logic          p_mid,
  input  logic          card_exit,
  input  logic          arith_done,
  output logic          win,
  output logic [15:0]   en
);

  localparam int CW   = $clog2(WORD_LEN);
  localparam int HALF = WORD_LEN / 2;
  localparam logic [3:0] C_MSTORE = 4'd0;
  localparam logic [3:0] C_MLOAD  = 4'd1;
  localparam logic [3:0] C_RREAD  = 4'd2;
  localparam logic [3:0] C_RWRITE = 4'd3;
  localparam logic [3:0] C_PUNCH  = 4'd4;
  localparam logic [3:0] C_CREAD  = 4'd5;
  localparam logic [3:0] C_IMM    = 4'd6;
  localparam logic [3:0] C_LOGIC  = 4'd7;
  localparam logic [3:0] C_ARITH  = 4'd8;
  localparam logic [3:0] C_STIM   = 4'd9;
  localparam logic [3:0] C_LAST   = C_STIM;

  logic          pend_q, win_q, match_q;
  logic [3:0]    type_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          close;

  wire idle    = !pend_q && !win_q;
  wire accept  = start && idle && (op_type <= C_LAST);
  wire opener  = (type_q == C_IMM) ? p_mid : p_first;
  wire opening = pend_q && opener;
  wire match   = (word_cnt == addr_q);

  always_comb begin
    case (type_q)
      C_MSTORE, C_MLOAD:                 close = match_q && !match;
      C_RREAD, C_RWRITE, C_LOGIC, C_STIM: close = (cnt_q == CW'(WORD_LEN - 1));
      C_IMM:                             close = (cnt_q == CW'(HALF - 1));
      C_PUNCH, C_CREAD:                  close = card_exit;
      C_ARITH:                           close = arith_done;
      default:                           close = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      win_q   <= 1'b0;
      match_q <= 1'b0;
      type_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      match_q <= match;
      if (accept) begin
        pend_q <= 1'b1;
        type_q <= op_type;
        addr_q <= addr;
      end
      if (opening) begin
        pend_q <= 1'b0;
        win_q  <= 1'b1;
        cnt_q  <= '0;
      end else if (win_q) begin
        if (close) win_q <= 1'b0;
        else       cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign win = win_q;
  assign en  = win_q ? (16'd1 << type_q) : 16'd0;

  AST_OPEN_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_q) |-> $past((type_q == C_IMM) ? p_mid : p_first)); // R3
  AST_MATCH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_q) && (type_q == C_MSTORE || type_q == C_MLOAD) |-> ($past(word_cnt) != addr_q)); // R5
  AST_CARD_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_q) && (type_q == C_PUNCH || type_q == C_CREAD) |-> $past(card_exit)); // R7
  AST_ARITH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_q) && (type_q == C_ARITH) |-> $past(arith_done)); // R8
  AST_CLASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    win_q && $past(win_q) |-> $stable(type_q) && $stable(addr_q)); // R9
  AST_LEGAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    win_q |-> (type_q <= C_LAST)); // R10
  AST_EN_TRACKS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en) && ((en != 16'd0) == win)); // R2

endmodule

// File: tb/sim_op_window_ctrl.sv
module sim_op_window_ctrl;
  localparam int CLK_P = 10;
  localparam int WL = 32;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, card_exit = 1'b0, arith_done = 1'b0;
  logic [3:0] op_type = '0;
  logic [AW-1:0] addr = '0, word_cnt = '0;
  int digit = 0;
  logic p_first, p_mid, win;
  logic [15:0] en;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  assign p_first = (digit == 0);
  assign p_mid   = (digit == WL/2);

  always @(negedge clk) begin
    digit <= (digit == WL-1) ? 0 : digit + 1;
    if (digit == WL-1) word_cnt <= word_cnt + 1'b1;
  end

  op_window_ctrl #(.WORD_LEN(WL), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_type(op_type), .addr(addr),
    .word_cnt(word_cnt), .p_first(p_first), .p_mid(p_mid),
    .card_exit(card_exit), .arith_done(arith_done), .win(win), .en(en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int code, input int k, input int d);
    case (code)
      0, 1:       return WL * (d + 1);
      6:          return WL / 2;
      4, 5, 8:    return k;
      default:    return WL;
    endcase
  endfunction

  function automatic string req_of(input int code);
    case (code)
      0, 1:    return "R5";
      6:       return "R4";
      4, 5:    return "R7";
      8:       return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic quiet(input int n, input string req);
    bit stray = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (win || en != 0) stray = 1;
    end
    chk(!stray, req, int'(stray), 0);
  endtask

  // poke_pend: second start while pending; poke_win: second start late in window
  task automatic run_op(input int code, input int k, input bit poke_pend, input bit poke_win);
    int cur, w, d, len, guard, odig, other;
    logic [AW-1:0] a;
    bit en_bad = 0, tied = 0;
    other = (code == 9) ? 2 : 9;
    cur = int'(word_cnt);
    a = AW'(cur + 2 + int'($urandom_range(0, 2)));
    @(negedge clk); start = 1; op_type = 4'(code); addr = a;
    @(negedge clk); start = 0;
    if (poke_pend) begin
      start = 1; op_type = 4'(other); addr = AW'(cur + 500);
      @(negedge clk); start = 0;
    end
    guard = 0;
    while (!win && guard < 3*WL) begin @(negedge clk); guard++; end
    chk(win == 1'b1, "R3", int'(win), 1);
    odig = digit; w = int'(word_cnt);
    chk(odig == ((code == 6) ? WL/2 : 0), (code == 6) ? "R4" : "R3", odig, (code == 6) ? WL/2 : 0);
    d = int'(AW'(a - AW'(w)));
    len = 0;
    while (win && len < 6*WL) begin
      len++;
      if (en != (16'd1 << code)) en_bad = 1;
      card_exit  = ((code == 4 || code == 5) && len == k) || (code < 4 && len == 3);
      arith_done = (code == 8 && len == k) || (code == 7 && len == 5);
      if (poke_win) begin
        start = (len >= exp_len(code, k, d) - 1);
        op_type = 4'(other);
      end
      @(negedge clk);
    end
    start = 0; card_exit = 0; arith_done = 0;
    chk(!en_bad, poke_pend ? "R9" : "R2", int'(en_bad), 0);
    chk(len == exp_len(code, k, d), req_of(code), len, exp_len(code, k, d));
    chk(en == 16'd0, "R2", int'(en), 0);
    if (poke_pend || poke_win) quiet(3*WL, "R9");
    if (tied) chk(1'b0, "R9", 1, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk(win == 0 && en == 0, "R1", int'(en), 0);
    @(negedge clk); rst_n = 1;
    quiet(WL, "R1");
    // directed corners
    run_op(2, 0, 0, 0);
    run_op(6, 0, 0, 0);
    run_op(0, 0, 0, 0);
    run_op(4, 1, 0, 0);
    run_op(8, 40, 0, 0);
    run_op(3, 0, 1, 0);
    run_op(9, 0, 0, 1);
    run_op(5, 2, 0, 1);
    // illegal code
    @(negedge clk); start = 1; op_type = 4'd12;
    @(negedge clk); start = 0;
    quiet(3*WL, "R10");
    run_op(7, 0, 0, 0);
    // random mix
    for (int i = 0; i < 40; i++) begin
      int c;
      c = int'($urandom_range(0, 9));
      repeat ($urandom_range(0, WL)) @(negedge clk);
      run_op(c, int'($urandom_range(1, 50)), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule